// File: doc/BRIEF.md
# Two-Voice Pulse Synthesizer with Cartridge Bus Front End and Mix-Read Interrupt

This block sits on an 8-bit processor cartridge bus and holds two square-wave tone voices. The processor programs each voice through a small write-only register window: a control byte (duty shape and loudness) and an 11-bit step period split across two bytes. A one-bit prescaler halves the bus clock. Each voice counts that half-rate tick down from its period, and every time the count runs out it advances an eight-step duty sequencer. While its sequencer is in a high step, the voice contributes its loudness to the mix; otherwise it contributes zero.

Whenever either voice's waveform rises or falls, a single interrupt flag is set and the open-drain interrupt line is pulled low. The service routine reads one fixed mix address. That read returns the sum of both voice levels on data lines 6..0 and acknowledges the interrupt. The routine then writes the value to an external DAC, so the processor acts as a software sample feeder that runs only when the output level changes.

A bus state machine follows each M2-high phase. It starts in BUS_IDLE. When M2 is seen high, it goes to BUS_WRITE for a matching register write, to BUS_READ for a read of the mix address, and to BUS_HOLD for any other access. BUS_WRITE commits for one cycle and then moves to BUS_HOLD, or to BUS_IDLE if M2 has already fallen. BUS_READ drives the data bus for as long as M2 stays high and moves to BUS_ACK when M2 falls. BUS_ACK clears the interrupt for one cycle and returns to BUS_IDLE, or to BUS_HOLD if a new M2 phase has started. BUS_HOLD waits for M2 low and then returns to BUS_IDLE.

Top module: `pulse_synth_bus`

## Requirements
- R1: After reset the interrupt output enable and the data output enable are low. Every voice has loudness 0, duty code 0 and period 0, so a mix read returns 0.
- R2: A write with the address offset bits [1:0] = 0 in voice slot v sets that voice's duty code from data bits 7..6 and its loudness from bits 3..0; bits 5..4 have no effect. Voice v's slot sits at 0x4020 + 4·v, where address bit 2 selects the voice. While the voice is in a high step it contributes its loudness to the mix, and otherwise 0.
- R3: Offset 2 loads period bits 7..0 from the data byte. Offset 3 loads period bits 10..8 from data bits 2..0, and data bits 7..3 have no effect.
- R4: With period P ≠ 0, each sequencer step lasts exactly 2·(P+1) bus clocks. With P = 0 the voice holds its step and produces no waveform edges.
- R5: Steps 0..7 repeat in order. The voice is high in steps 0..c, where c is the duty code, giving 1, 2, 3 or 4 high steps out of 8.
- R6: A rise or fall of any voice's waveform sets the interrupt flag, and the interrupt output enable is high from the next clock. The interrupt output value is always 0.
- R7: A read (R/W high, /ROMSEL high) of address 0x4011 puts the state machine in BUS_READ one clock after M2 is first sampled high. From then on, while M2 stays high, the data output enable is high and data lines 6..0 carry the zero-extended sum of both voice levels (0..30). The output enable drops one clock after M2 is sampled low.
- R8: One clock after the mix read's M2 is sampled low, BUS_ACK is active, and the flag is clear on the following clock. Reads at any other address neither drive the bus nor clear the flag.
- R9: If a waveform edge arrives in the same clock as BUS_ACK, the flag stays set.
- R10: Writes with /ROMSEL low, writes at offset 1, and writes outside 0x4020..0x4027 change no voice state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, twice the voice tick rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_m2 | input | 1 | Bus phase; high during the data phase of an access |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_romsel_n | input | 1 | Low for accesses in the upper half of the address map |
| cpu_addr | input | 15 | Address lines 14..0 |
| cpu_d7 | input | 1 | Data bit 7 (write only) |
| cpu_d_in | input | 7 | Data bits 6..0 as driven by the processor |
| cpu_d_out | output | 7 | Data bits 6..0 driven for a mix read |
| cpu_d_oe | output | 1 | Output enable for cpu_d_out |
| irq_n_oe | output | 1 | Pulls the open-drain interrupt line when high |
| irq_n_out | output | 1 | Value for the interrupt line, constant 0 |

## Verification
A register write takes effect on the second clock edge after M2 is raised. The mix value and data enable are due one edge after M2 rises, the flag clears two edges after M2 falls, and the interrupt enable follows a waveform edge by one clock. The bench drives every input on falling clock edges, counts rising edges, and samples exactly one half-cycle after the edge that owes each result. Step timing and duty are checked as exact gaps between successive interrupt rises, measured on that same edge counter. The overlap case is built by timing the start of a mix read from a measured interrupt, so that BUS_ACK lands in the clock of the next expected waveform edge.

// File: rtl/pulse_synth_pkg.sv
package pulse_synth_pkg;
    localparam int VOL_W  = 4;
    localparam int TIM_W  = 2;
    localparam int PER_W  = 11;
    localparam int SEQ_W  = 3;
    localparam int OFS_W  = 2;
    localparam int BYTE_W = 8;

    localparam logic [OFS_W-1:0] OFS_CTRL   = 2'd0;
    localparam logic [OFS_W-1:0] OFS_PER_LO = 2'd2;
    localparam logic [OFS_W-1:0] OFS_PER_HI = 2'd3;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_WRITE,
        BUS_READ,
        BUS_ACK,
        BUS_HOLD
    } bus_state_e;
endpackage

// File: rtl/synth_bus_fsm.sv
module synth_bus_fsm
    import pulse_synth_pkg::*;
#(
    parameter int              ADDR_W   = 15,
    parameter int              WIN_LSB  = 3,
    parameter logic [ADDR_W-1:0] REG_BASE = 15'h4020,
    parameter logic [ADDR_W-1:0] MIX_ADDR = 15'h4011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2,
    input  logic              rw,
    input  logic              romsel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_stb,
    output logic              rd_drive,
    output logic              rd_ack
);
    bus_state_e state_q, state_d;

    logic win_hit;
    logic mix_hit;

    assign win_hit = (addr[ADDR_W-1:WIN_LSB] == REG_BASE[ADDR_W-1:WIN_LSB]);
    assign mix_hit = (addr == MIX_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (m2) begin
                    if (romsel_n && !rw && win_hit)     state_d = BUS_WRITE;
                    else if (romsel_n && rw && mix_hit) state_d = BUS_READ;
                    else                                state_d = BUS_HOLD;
                end
            end
            BUS_WRITE: state_d = m2 ? BUS_HOLD : BUS_IDLE;
            BUS_READ:  state_d = m2 ? BUS_READ : BUS_ACK;
            BUS_ACK:   state_d = m2 ? BUS_HOLD : BUS_IDLE;
            BUS_HOLD:  state_d = m2 ? BUS_HOLD : BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_stb   = 1'b0;
        rd_drive = 1'b0;
        rd_ack   = 1'b0;
        unique case (state_q)
            BUS_WRITE: wr_stb   = 1'b1;
            BUS_READ:  rd_drive = 1'b1;
            BUS_ACK:   rd_ack   = 1'b1;
            default: ;
        endcase
    end

    // R7: bus is only driven after M2 was seen high
    assert_drive_in_m2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(m2));

    // R10: a commit only follows a sampled write with /ROMSEL high
    assert_write_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!rw && romsel_n));
endmodule

// File: rtl/synth_tone_voice.sv
module synth_tone_voice
    import pulse_synth_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [VOL_W-1:0]  level,
    output logic              wave_edge
);
    localparam int HI_W = PER_W - BYTE_W;

    logic [TIM_W-1:0] duty_q;
    logic [VOL_W-1:0] loud_q;
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] count_q;
    logic [SEQ_W-1:0] step_q;
    logic             wave_q;
    logic             wave_now;

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q   <= '0;
            loud_q   <= '0;
            period_q <= '0;
        end else if (wr_en) begin
            unique case (wr_ofs)
                OFS_CTRL: begin
                    duty_q <= wr_data[BYTE_W-1 -: TIM_W];
                    loud_q <= wr_data[VOL_W-1:0];
                end
                OFS_PER_LO: period_q[BYTE_W-1:0]     <= wr_data;
                OFS_PER_HI: period_q[PER_W-1:BYTE_W] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // period divider and step sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            step_q  <= '0;
        end else if (tick && (period_q != '0)) begin
            if (count_q == '0) begin
                count_q <= period_q;
                step_q  <= step_q + 1'b1;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign wave_now = (step_q <= SEQ_W'(duty_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b1;
        else        wave_q <= wave_now;
    end

    assign wave_edge = wave_now ^ wave_q;
    assign level     = wave_now ? loud_q : '0;

    // R4: a zero period freezes the sequencer
    assert_halt_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) |=> $stable(step_q));
endmodule

// File: rtl/synth_irq_flag.sv
module synth_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (ack_i) flag_o <= 1'b0;
    end

    // R9: an edge in the acknowledge cycle is kept
    assert_set_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && ack_i) |=> flag_o);

    // R8: a lone acknowledge releases the line
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pulse_synth_bus.sv
module pulse_synth_bus
    import pulse_synth_pkg::*;
#(
    parameter int                NUM_CH   = 2,
    parameter int                ADDR_W   = 15,
    parameter int                DBUS_W   = 7,
    parameter logic [ADDR_W-1:0] REG_BASE = 15'h4020,
    parameter logic [ADDR_W-1:0] MIX_ADDR = 15'h4011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_m2,
    input  logic              cpu_rw,
    input  logic              cpu_romsel_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_d7,
    input  logic [DBUS_W-1:0] cpu_d_in,
    output logic [DBUS_W-1:0] cpu_d_out,
    output logic              cpu_d_oe,
    output logic              irq_n_oe,
    output logic              irq_n_out
);
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WIN_LSB = OFS_W + CH_W;
    localparam int SUM_W   = VOL_W + CH_W;

    logic              wr_stb;
    logic              rd_drive;
    logic              rd_ack;
    logic              tick_q;
    logic [BYTE_W-1:0] wr_byte;
    logic [VOL_W-1:0]  lvl [NUM_CH];
    logic [NUM_CH-1:0] edges;
    logic [SUM_W-1:0]  mix_sum;
    logic              irq_flag;

    assign wr_byte = {cpu_d7, cpu_d_in};

    synth_bus_fsm #(
        .ADDR_W   (ADDR_W),
        .WIN_LSB  (WIN_LSB),
        .REG_BASE (REG_BASE),
        .MIX_ADDR (MIX_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .m2       (cpu_m2),
        .rw       (cpu_rw),
        .romsel_n (cpu_romsel_n),
        .addr     (cpu_addr),
        .wr_stb   (wr_stb),
        .rd_drive (rd_drive),
        .rd_ack   (rd_ack)
    );

    // halves the bus clock for the voice dividers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= ~tick_q;
    end

    for (genvar v = 0; v < NUM_CH; v++) begin : g_voice
        logic sel;
        assign sel = wr_stb && (cpu_addr[OFS_W +: CH_W] == CH_W'(v));

        synth_tone_voice u_voice (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_q),
            .wr_en     (sel),
            .wr_ofs    (cpu_addr[OFS_W-1:0]),
            .wr_data   (wr_byte),
            .level     (lvl[v]),
            .wave_edge (edges[v])
        );
    end

    always_comb begin
        mix_sum = '0;
        for (int v = 0; v < NUM_CH; v++) mix_sum = mix_sum + SUM_W'(lvl[v]);
    end

    synth_irq_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (|edges),
        .ack_i  (rd_ack),
        .flag_o (irq_flag)
    );

    assign cpu_d_out = DBUS_W'(mix_sum);
    assign cpu_d_oe  = rd_drive;
    assign irq_n_oe  = irq_flag;
    assign irq_n_out = 1'b0;

    // R6: any waveform edge pulls the line on the next clock
    assert_edge_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|edges) |=> irq_n_oe);
endmodule

// File: tb/pulse_synth_bus_test.sv
`timescale 1ns/1ps
module pulse_synth_bus_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m2 = 1'b0;
    logic        rw = 1'b1;
    logic        romsel_n = 1'b1;
    logic [14:0] addr = '0;
    logic        d7 = 1'b0;
    logic [6:0]  d_in = '0;
    logic [6:0]  d_out;
    logic        d_oe;
    logic        irq_oe;
    logic        irq_val;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_synth_bus uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_m2       (m2),
        .cpu_rw       (rw),
        .cpu_romsel_n (romsel_n),
        .cpu_addr     (addr),
        .cpu_d7       (d7),
        .cpu_d_in     (d_in),
        .cpu_d_out    (d_out),
        .cpu_d_oe     (d_oe),
        .irq_n_oe     (irq_oe),
        .irq_n_out    (irq_val)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d, input logic rs_n);
        @(negedge clk);
        rw = 1'b0; romsel_n = rs_n; addr = a; d7 = d[7]; d_in = d[6:0]; m2 = 1'b1;
        @(negedge clk);
        m2 = 1'b0;
        @(negedge clk);
        rw = 1'b1; romsel_n = 1'b1; addr = '0;
    endtask

    task automatic bus_read(input logic [14:0] a, output logic [6:0] val,
                            output logic oe_mid, output logic oe_after);
        @(negedge clk);
        rw = 1'b1; romsel_n = 1'b1; addr = a; m2 = 1'b1;
        @(negedge clk);
        val = d_out; oe_mid = d_oe; m2 = 1'b0;
        @(negedge clk);
        oe_after = d_oe;
        @(negedge clk);
    endtask

    task automatic ack();
        logic [6:0] v; logic o1, o2;
        bus_read(15'h4011, v, o1, o2);
    endtask

    task automatic wait_irq(output int t);
        int guard = 0;
        @(negedge clk);
        while (!irq_oe && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
        check(irq_oe, "R6 interrupt never raised", 0, 1);
        t = cyc;
    endtask

    // {is_write, address, data byte, expected mix}
    localparam int NV = 15;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0, 15'h4011, 8'h00, 7'd0},
        {1'b1, 15'h4020, 8'hC5, 7'd0},
        {1'b0, 15'h4011, 8'h00, 7'd5},
        {1'b1, 15'h4024, 8'h09, 7'd0},
        {1'b0, 15'h4011, 8'h00, 7'd14},
        {1'b1, 15'h4021, 8'h0F, 7'd0},
        {1'b0, 15'h4011, 8'h00, 7'd14},
        {1'b1, 15'h4020, 8'h3A, 7'd0},
        {1'b0, 15'h4011, 8'h00, 7'd19},
        {1'b1, 15'h4020, 8'hC5, 7'd0},
        {1'b0, 15'h4011, 8'h00, 7'd14},
        {1'b1, 15'h4025, 8'hFF, 7'd0},
        {1'b0, 15'h4011, 8'h00, 7'd14},
        {1'b1, 15'h4028, 8'h0F, 7'd0},
        {1'b0, 15'h4011, 8'h00, 7'd14}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] v; logic o1, o2;
        int t1, t2, t3, t4, ta, tb, tc, tx;

        repeat (3) @(negedge clk);
        check(irq_oe == 1'b0, "R1 irq enable at reset", irq_oe, 0);
        check(d_oe == 1'b0, "R1 data enable at reset", d_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table: R1 R2 R7 R10
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][30]) begin
                bus_write(VEC[i][29:15], VEC[i][14:7], 1'b1);
            end else begin
                bus_read(VEC[i][29:15], v, o1, o2);
                check(v == VEC[i][6:0], $sformatf("R7/R2/R10 vector %0d mix", i), v, VEC[i][6:0]);
                check(o1 == 1'b1, $sformatf("R7 vector %0d drive during M2", i), o1, 1);
                check(o2 == 1'b0, $sformatf("R7 vector %0d release after M2", i), o2, 0);
            end
        end

        // R10: /ROMSEL low write ignored
        bus_write(15'h4020, 8'h0F, 1'b0);
        bus_read(15'h4011, v, o1, o2);
        check(v == 7'd14, "R10 romsel low write ignored", v, 14);

        // R4: zero periods produce no edges; R6 value constant low
        check(irq_oe == 1'b0, "R4 halted voices raise no interrupt", irq_oe, 0);
        check(irq_val == 1'b0, "R6 interrupt value low", irq_val, 0);

        // R8: other reads never drive
        bus_read(15'h4012, v, o1, o2);
        check(o1 == 1'b0, "R8 read of other address not driven", o1, 0);
        bus_read(15'h4020, v, o1, o2);
        check(o1 == 1'b0, "R8 read of register window not driven", o1, 0);

        // voice 0 runs with P=3 (50% duty, loudness 5), voice 1 held high at 9
        bus_write(15'h4022, 8'h03, 1'b1);
        bus_write(15'h4023, 8'h00, 1'b1);
        wait_irq(tx);
        ack();
        wait_irq(t1);
        check(irq_val == 1'b0, "R6 interrupt value low while pulled", irq_val, 0);
        bus_read(15'h4012, v, o1, o2);
        check(irq_oe == 1'b1, "R8 other read does not acknowledge", irq_oe, 1);
        bus_read(15'h4011, v, o1, o2);
        ta = v;
        check(irq_oe == 1'b0, "R8 mix read acknowledges", irq_oe, 0);
        wait_irq(t2);
        check(t2 - t1 == 32, "R4 edge spacing for P=3", t2 - t1, 32);
        bus_read(15'h4011, v, o1, o2);
        tb = v;
        check(ta + tb == 23 && ta != tb, "R2/R5 mix alternates 14 and 9", ta + tb, 23);

        // R9: acknowledge lands in the clock of the next edge
        while (cyc != t2 + 29) @(negedge clk);
        rw = 1'b1; romsel_n = 1'b1; addr = 15'h4011; m2 = 1'b1;
        @(negedge clk);
        m2 = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(irq_oe == 1'b1, "R9 edge during acknowledge kept", irq_oe, 1);
        @(negedge clk);
        check(irq_oe == 1'b1, "R9 flag still set next clock", irq_oe, 1);
        ack();

        // R3: high period bits from data bits 2..0 only -> P = 259
        bus_write(15'h4023, 8'hF9, 1'b1);
        wait_irq(tx);
        ack();
        wait_irq(t3);
        ack();
        wait_irq(t4);
        check(t4 - t3 == 2080, "R3 period high bits", t4 - t3, 2080);
        ack();
        bus_write(15'h4023, 8'h00, 1'b1);

        // R5: each duty code with P=3 (8 clocks per step)
        for (int c = 0; c < 4; c++) begin
            int hi, lo, d1, d2;
            bus_write(15'h4020, {c[1:0], 6'h05}, 1'b1);
            wait_irq(tx); ack();
            wait_irq(tx); ack();
            wait_irq(ta); ack();
            wait_irq(tb); ack();
            wait_irq(tc); ack();
            hi = 8 * (c + 1);
            lo = 64 - hi;
            d1 = tb - ta;
            d2 = tc - tb;
            check((d1 == hi && d2 == lo) || (d1 == lo && d2 == hi),
                  $sformatf("R5 duty code %0d high time", c), (d1 < d2) ? d1 : d2,
                  (hi < lo) ? hi : lo);
        end

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(irq_oe == 1'b0, "R1 irq released by reset", irq_oe, 0);
        rst_n = 1'b1;
        bus_read(15'h4011, v, o1, o2);
        check(v == 7'd0, "R1 mix zero after reset", v, 0);
        repeat (100) @(negedge clk);
        check(irq_oe == 1'b0, "R1 voices halted after reset", irq_oe, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule